// File: doc/BRIEF.md
# Wide Instruction Streaming Sequencer

This block feeds an array of simple evaluation units with very long instruction words held in a board memory. The memory bus is narrower than an instruction. Each instruction is therefore read as `NB = ceil(IW/BW)` consecutive bus beats. The beats are reassembled into one word, and that word is presented to the array with a one-clock valid strobe. One pass over the compiled instruction list evaluates the modelled logic once, for one input vector. At the end of each pass the block takes the result vector from the array and writes it back to memory. It then starts the next pass at the first instruction, and repeats until every vector has been processed.

The memory is single-ported and shared with a host. The block claims the port only between a start request and its final result write. After that it raises `done` and hands the port back to the host.

The memory returns read data one clock after a read request. The instruction count, vector count and both base addresses are taken when `start` is accepted. The result port must not be wider than the bus (`RW <= BW`).

Top module: `wide_instr_sequencer`

## Requirements
- R1: Each instruction i of a pass is read as NB consecutive single-cycle read requests. Beat b of instruction i is read at address `instrBase + i*NB + b`, so one pass reads the addresses from `instrBase` upward in unbroken order, one request per clock.
- R2: Read beat b lands in bits `[b*BW +: BW]` of the assembled word, so beat 0 supplies the least significant bits. Data bits of the final beat above position IW are ignored and never appear on `instrWord`.
- R3: `instrValid` is high for one clock per instruction, two clocks after the read request of that instruction's final beat. `instrWord` holds the complete instruction in that clock. With NB > 1 the strobe is never high in two consecutive clocks.
- R4: With N > 0 instructions, each vector takes `N*NB + 3` clocks. With N = 0 it takes 1 clock. `done` becomes visible V times that many clocks after the clock edge that accepts `start`.
- R5: Every pass starts reading at `instrBase` again.
- R6: After each pass the block issues exactly one write. It falls in the clock after that pass's last `instrValid`, or directly after the previous write when N = 0. Its address is `resultBase + v` for vector v, and its data is `resultIn` zero-extended to BW bits.
- R7: `memOwn` is high from the clock after `start` is accepted up to and including the last result write. `memRe` and `memWe` are high only while `memOwn` is high, and never together.
- R8: `done` rises after the final write and stays high until the next accepted `start`, with `memOwn` low. A `start` pulse during a run is ignored. A vector count of 0 raises `done` at once, without any memory access.
- R9: During and directly after reset, `memOwn`, `memRe`, `memWe`, `instrValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only while idle |
| instrCount | input | CW | Number of compiled instructions N |
| vecCount | input | CW | Number of simulation vectors V |
| instrBase | input | AW | Memory address of beat 0 of instruction 0 |
| resultBase | input | AW | Memory address of the result of vector 0 |
| memOwn | output | 1 | Block owns the memory port; host must stay off |
| memRe | output | 1 | Read request; data returns the next clock |
| memWe | output | 1 | Write request |
| memAddr | output | AW | Memory word address |
| memWdata | output | BW | Write data |
| memRdata | input | BW | Read data, one clock after `memRe` |
| instrWord | output | IW | Reassembled instruction, valid with `instrValid` |
| instrValid | output | 1 | One-clock strobe per complete instruction |
| resultIn | input | RW | Result vector from the evaluation array |
| done | output | 1 | All vectors processed; port released |

## Verification
On every cycle the embedded assertions check the port-ownership rules of R7 and R8 and the strict address stepping within a pass (R1). They also check that each pass returns to the base address (R5), and that every strobe follows a final-beat capture and is never doubled (R3). They cannot see whether the reassembled word has the right bit order, whether padding is discarded, or whether the written result and its address are correct, because those depend on memory contents. The bench covers them: it serves address-derived patterns with nonzero padding and compares every instruction and every write with words it computes itself. The bench also covers the per-vector clock budget of R4, zero-instruction and zero-vector runs, and a `start` pulse ignored in mid-run.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // Widest beat selector carried in the strobe struct (up to 256 beats).
  localparam int SEL_MAX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DRAIN1 = 3'd2,
    ST_DRAIN2 = 3'd3,
    ST_WRITE  = 3'd4
  } seqState_t;

  // Strobes from control to datapath, aligned to the cycle read data is present.
  typedef struct packed {
    logic                 capture;
    logic                 lastBeat;
    logic [SEL_MAX_W-1:0] beatSel;
    logic                 resultWrite;
  } dpStrobe_t;

endpackage

// File: rtl/wis_ctrl.sv
module wis_ctrl
  import wis_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] instrCount,
  input  logic [CW-1:0] vecCount,
  input  logic [AW-1:0] instrBase,
  input  logic [AW-1:0] resultBase,
  output logic          memOwn,
  output logic          memRe,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic          done,
  output dpStrobe_t     strobe
);

  localparam int BCW = (NB > 1) ? $clog2(NB) : 1;

  seqState_t     state;
  logic [CW-1:0] nInstr, nVec, instrCnt, vecCnt;
  logic [AW-1:0] baseI, baseR, offset;
  logic [BCW-1:0] beatCnt, selP;
  logic          capP, lastP;
  logic          beatLast, instrLast, vecLast;

  assign beatLast  = (beatCnt == BCW'(NB - 1));
  assign instrLast = (instrCnt == nInstr - CW'(1));
  assign vecLast   = (vecCnt == nVec - CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nInstr   <= '0;
      nVec     <= '0;
      baseI    <= '0;
      baseR    <= '0;
      offset   <= '0;
      beatCnt  <= '0;
      instrCnt <= '0;
      vecCnt   <= '0;
      capP     <= 1'b0;
      lastP    <= 1'b0;
      selP     <= '0;
      done     <= 1'b0;
    end else begin
      // Read data returns one clock after the request; tag it here.
      capP  <= (state == ST_FETCH);
      lastP <= (state == ST_FETCH) && beatLast;
      selP  <= beatCnt;
      case (state)
        ST_IDLE: begin
          if (start) begin
            nInstr   <= instrCount;
            nVec     <= vecCount;
            baseI    <= instrBase;
            baseR    <= resultBase;
            offset   <= '0;
            beatCnt  <= '0;
            instrCnt <= '0;
            vecCnt   <= '0;
            if (vecCount == '0) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              state <= (instrCount == '0) ? ST_WRITE : ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          offset <= offset + AW'(1);
          if (beatLast) begin
            beatCnt  <= '0;
            instrCnt <= instrCnt + CW'(1);
            if (instrLast) state <= ST_DRAIN1;
          end else begin
            beatCnt <= beatCnt + BCW'(1);
          end
        end
        ST_DRAIN1: state <= ST_DRAIN2;
        ST_DRAIN2: state <= ST_WRITE;
        ST_WRITE: begin
          offset   <= '0;
          beatCnt  <= '0;
          instrCnt <= '0;
          if (vecLast) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            vecCnt <= vecCnt + CW'(1);
            state  <= (nInstr == '0) ? ST_WRITE : ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memOwn  = (state != ST_IDLE);
    memRe   = (state == ST_FETCH);
    memWe   = (state == ST_WRITE);
    memAddr = '0;
    if (state == ST_FETCH)      memAddr = baseI + offset;
    else if (state == ST_WRITE) memAddr = baseR + AW'(vecCnt);
    strobe.capture     = capP;
    strobe.lastBeat    = lastP;
    strobe.beatSel     = SEL_MAX_W'(selP);
    strobe.resultWrite = memWe;
  end

  // R7: memory traffic only while the port is held, never read and write at once.
  a_r7_access_owned: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> memOwn);
  a_r7_no_rw_both: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));
  // R8: the port is released whenever done is shown.
  a_r8_done_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memOwn);
  // R1: back-to-back reads step the address by one.
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> (memAddr == $past(memAddr) + AW'(1)));
  // R5: the first read of each pass is at the instruction base.
  a_r5_restart_base: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && !$past(memRe)) |-> (memAddr == instrBase));

endmodule

// File: rtl/wis_dpath.sv
module wis_dpath
  import wis_pkg::*;
#(
  parameter int IW = 600,
  parameter int BW = 256,
  parameter int RW = 64,
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [BW-1:0] memRdata,
  input  logic [RW-1:0] resultIn,
  output logic [IW-1:0] instrWord,
  output logic          instrValid,
  output logic [BW-1:0] memWdata
);

  // Width carried by the final beat; bits above it are padding.
  localparam int LASTW = IW - (NB - 1) * BW;

  logic [IW-1:0] asmWord;

  genvar b;
  generate
    for (b = 0; b < NB - 1; b++) begin : g_fullBeat
      always_ff @(posedge clk) begin
        if (strobe.capture && strobe.beatSel == SEL_MAX_W'(b))
          asmWord[b*BW +: BW] <= memRdata;
      end
    end
    always_ff @(posedge clk) begin
      if (strobe.capture && strobe.beatSel == SEL_MAX_W'(NB - 1))
        asmWord[IW-1 -: LASTW] <= memRdata[LASTW-1:0];
    end
    if (LASTW < BW) begin : g_pad
      logic unusedPad;
      assign unusedPad = ^memRdata[BW-1:LASTW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) instrValid <= 1'b0;
    else       instrValid <= strobe.capture && strobe.lastBeat;
  end

  assign instrWord = asmWord;
  assign memWdata  = strobe.resultWrite ? BW'(resultIn) : '0;

  // R3: every strobe follows the capture of a final beat.
  a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |-> $past(strobe.capture && strobe.lastBeat));

  generate
    if (NB > 1) begin : g_pulseChk
      // R3: split instructions never produce adjacent strobes.
      a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
        instrValid |=> !instrValid);
    end
  endgenerate

endmodule

// File: rtl/wide_instr_sequencer.sv
module wide_instr_sequencer
  import wis_pkg::*;
#(
  parameter int IW = 600,
  parameter int BW = 256,
  parameter int RW = 64,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] instrCount,
  input  logic [CW-1:0] vecCount,
  input  logic [AW-1:0] instrBase,
  input  logic [AW-1:0] resultBase,
  output logic          memOwn,
  output logic          memRe,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [BW-1:0] memWdata,
  input  logic [BW-1:0] memRdata,
  output logic [IW-1:0] instrWord,
  output logic          instrValid,
  input  logic [RW-1:0] resultIn,
  output logic          done
);

  localparam int NB = (IW + BW - 1) / BW;

  dpStrobe_t strobe;

  wis_ctrl #(.AW(AW), .CW(CW), .NB(NB)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .instrCount(instrCount), .vecCount(vecCount),
    .instrBase(instrBase), .resultBase(resultBase),
    .memOwn(memOwn), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .done(done), .strobe(strobe)
  );

  wis_dpath #(.IW(IW), .BW(BW), .RW(RW), .NB(NB)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memRdata(memRdata), .resultIn(resultIn),
    .instrWord(instrWord), .instrValid(instrValid), .memWdata(memWdata)
  );

endmodule

// File: tb/tb_wide_instr_sequencer.sv
module tb_wide_instr_sequencer;

  localparam int IW = 600;
  localparam int BW = 256;
  localparam int RW = 64;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NB = (IW + BW - 1) / BW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] instrCount = '0, vecCount = '0;
  logic [AW-1:0] instrBase = '0, resultBase = '0;
  logic memOwn, memRe, memWe, instrValid, done;
  logic [AW-1:0] memAddr;
  logic [BW-1:0] memWdata;
  logic [BW-1:0] memRdata = '0;
  logic [IW-1:0] instrWord;
  logic [RW-1:0] resultIn;

  always #2.5 clk = ~clk;

  wide_instr_sequencer #(.IW(IW), .BW(BW), .RW(RW), .AW(AW), .CW(CW)) dut (.*);

  int testCnt = 0, failCnt = 0;
  logic [31:0] salt = 32'h1234_5678;
  int curN = 0, curV = 0;
  int readIdx = 0, valIdx = 0, wrCnt = 0;
  int totReads = 0, totValid = 0;
  bit prevValid = 0, monOn = 0;

  task automatic chk(input bit ok, input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] pat(input logic [AW-1:0] a);
    logic [BW-1:0] r;
    for (int j = 0; j < BW / 32; j++)
      r[j*32 +: 32] = ({16'h0, a} * 32'h9E37_79B1) ^ (j * 32'h85EB_CA6B) ^ salt;
    return r;
  endfunction

  function automatic logic [IW-1:0] expInstr(input int i);
    logic [NB*BW-1:0] f;
    for (int b = 0; b < NB; b++) f[b*BW +: BW] = pat(instrBase + AW'(i * NB + b));
    return f[IW-1:0];
  endfunction

  function automatic logic [RW-1:0] resFn(input int v);
    return {32'(v) * 32'h2545_F491 ^ salt, salt + 32'(v)};
  endfunction

  assign resultIn = resFn(wrCnt);

  // Memory model: contents derived from address, one-clock read latency.
  always @(posedge clk) memRdata <= memRe ? pat(memAddr) : '0;

  always @(negedge clk) begin
    if (monOn) begin
      if (memRe) begin
        chk(memAddr == instrBase + AW'(readIdx), "R1 read address", memAddr, instrBase + AW'(readIdx));
        chk(memOwn == 1'b1, "R7 read while owned", memOwn, 1);
        readIdx++; totReads++;
      end
      if (instrValid) begin
        chk(instrWord == expInstr(valIdx), "R2 instruction word", instrWord, expInstr(valIdx));
        chk(!prevValid, "R3 strobe not adjacent", prevValid, 0);
        valIdx++; totValid++;
      end
      if (memWe) begin
        chk(!memRe, "R7 no read with write", memRe, 0);
        chk(memAddr == resultBase + AW'(wrCnt), "R6 result address", memAddr, resultBase + AW'(wrCnt));
        chk(memWdata == BW'(resFn(wrCnt)), "R6 result data", memWdata, BW'(resFn(wrCnt)));
        chk(valIdx == curN, "R6 all instructions before write", valIdx, curN);
        chk(readIdx == curN * NB, "R5 reads per pass", readIdx, curN * NB);
        if (curN > 0) chk(prevValid, "R6 write follows last strobe", prevValid, 1);
        wrCnt++; readIdx = 0; valIdx = 0;
      end
      if (done) chk(!memOwn, "R8 port released", memOwn, 0);
    end
    prevValid = instrValid;
  end

  task automatic runCase(input int v, input int n, input logic [AW-1:0] ib,
                         input logic [AW-1:0] rb, input bit poke);
    int cyc, expCyc;
    @(negedge clk);
    salt = $urandom;
    curN = n; curV = v;
    instrCount = CW'(n); vecCount = CW'(v);
    instrBase = ib; resultBase = rb;
    readIdx = 0; valIdx = 0; wrCnt = 0; totReads = 0; totValid = 0;
    monOn = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      if (v > 0) chk(memOwn == 1'b1, "R7 owned during run", memOwn, 1);
      @(negedge clk);
      cyc++;
      start = poke && (cyc == 4);
    end
    start = 1'b0;
    expCyc = v * ((n > 0) ? n * NB + 3 : 1) + 1;
    chk(cyc == expCyc, "R4 cycles to done", cyc, expCyc);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8 done holds", done, 1);
    chk(memOwn == 1'b0, "R8 port released after run", memOwn, 0);
    chk(wrCnt == v, "R6 one write per vector", wrCnt, v);
    chk(totValid == v * n, "R3 strobe count", totValid, v * n);
    chk(totReads == v * n * NB, "R1 read count", totReads, v * n * NB);
    monOn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk({memOwn, memRe, memWe, instrValid, done} == 5'b0, "R9 outputs in reset",
        {memOwn, memRe, memWe, instrValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({memOwn, memRe, memWe, instrValid, done} == 5'b0, "R9 outputs after reset",
        {memOwn, memRe, memWe, instrValid, done}, 0);
    // Directed corners
    runCase(2, 3, 16'h0100, 16'h4000, 0);
    runCase(1, 1, 16'h0000, 16'h0010, 0);
    runCase(3, 0, 16'h0200, 16'h5000, 0);   // no instructions
    runCase(0, 4, 16'h0300, 16'h6000, 0);   // no vectors
    runCase(3, 4, 16'h0400, 16'h7000, 1);   // start pulse while busy
    // Random mix
    for (int k = 0; k < 8; k++)
      runCase(1 + ($urandom % 4), 1 + ($urandom % 7),
              AW'($urandom % 16'hE000), AW'(16'hF000 + ($urandom % 16'h0800)), 0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule